// File: doc/BRIEF.md
# GCM Field Multiplier with 64-bit Carry-less Partials

This block multiplies two 128-bit elements of GF(2^128) with the bit-reflected convention that GHASH in Galois/Counter Mode uses. Each operand arrives as a 16-byte string on a flat 128-bit bus. Byte k of the string sits on bits [8k+7:8k]. The most significant bit of byte 0 is the coefficient of x^0, and the least significant bit of byte 15 is the coefficient of x^127. The result uses the same layout.

The operands are first put into byte-reversed order. The 255-bit carry-less product is then built from four 64x64 carry-less multiplies. That product is shifted left by one bit to correct for the reflected bit order. The product is then reduced with two folds against a constant that has 0xE1 in its top byte, and each fold term also gets the one-bit correction. The byte order of the result is reversed back at the output. A single 64x64 carry-less multiplier does all seven multiplies, one per cycle.

A caller pulses `start` with both operands valid. Eight clock edges later `done` is high for one cycle, and `product` holds the result until the next result replaces it. While a computation runs, `start` is ignored.

Top module: `gcm_gfmul`

## Requirements
- R1: Bus layout. The most significant bit of byte 0 (bus bit 7) is the coefficient of x^0, and the least significant bit of byte 15 (bus bit 120) is the coefficient of x^127. As a result, x (0x40 in byte 0) times x^127 gives the reduction remainder 0xE1 in byte 0, with all other bytes zero.
- R2: For any pair of operands, `product` equals the bit-serial GCM multiply. That multiply shifts right and XORs 0xE1 followed by 120 zero bits whenever the bit shifted out is one.
- R3: If either operand is zero, the product is zero.
- R4: The unit element (0x80 in byte 0, every other byte zero) returns the other operand unchanged, from either side.
- R5: When both operands are all ones, both reduction folds are exercised, and the result matches the bit-serial multiply.
- R6: If `start` is sampled high while the block is idle, `done` is high for exactly one cycle, in the cycle after the eighth rising edge counted from that sample.
- R7: If `start` is high while a computation is running, it has no effect. The running result and its timing are unchanged, and no extra `done` follows.
- R8: `product` changes only in a cycle where `done` is high. Between pulses it holds the last result.
- R9: A `start` in the same cycle that `done` is high is accepted. The next result follows eight edges later.
- R10: After synchronous reset, `done` is 0 and `product` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiply with the present operands |
| opnd_x | input | 128 | First operand, byte k on bits [8k+7:8k] |
| opnd_y | input | 128 | Second operand, same layout |
| done | output | 1 | One-cycle pulse when `product` has been updated |
| product | output | 128 | Field product, same byte layout, held between pulses |

## Verification
Two events can meet in one cycle: a new `start` and either a computation still in flight or the `done` pulse of the previous one. The bench raises `start` with different operands in the middle of a run. It then checks that the first result still arrives on time and unchanged, and that no second pulse appears afterwards. It also raises `start` exactly in the cycle where `done` is seen. In that case it expects the first result to be valid in that cycle and the second result eight edges later. Both results are judged against the bit-serial reference.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    localparam int BYTE_W    = 8;
    localparam int BLK_BYTES = 16;
    localparam int BLK_W     = BYTE_W * BLK_BYTES;
    localparam int LANE_W    = BLK_W / 2;
    localparam int WIDE_W    = 2 * BLK_W;
    localparam int LPROD_W   = 2 * LANE_W;
    // a 128x128 carry-less product never sets bit 255
    localparam int PROD_W    = WIDE_W - 1;
    // the first fold occupies bits 64..254 of a 256-bit word
    localparam int FR_W      = WIDE_W - LANE_W - 1;
    localparam int N_STEPS   = 7;
    localparam int STEP_W    = $clog2(N_STEPS);

    typedef logic [BLK_W-1:0]   blk_t;
    typedef logic [LANE_W-1:0]  lane_t;
    typedef logic [WIDE_W-1:0]  wide_t;
    typedef logic [LPROD_W-1:0] lprod_t;
    typedef logic [PROD_W-1:0]  prod_t;
    typedef logic [FR_W-1:0]    fold_t;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } state_e;

    // multiply order: four product partials, then two first-fold halves,
    // then the second fold
    typedef enum logic [STEP_W-1:0] {
        STP_LL  = 3'd0,
        STP_LH  = 3'd1,
        STP_HL  = 3'd2,
        STP_HH  = 3'd3,
        STP_F1L = 3'd4,
        STP_F1H = 3'd5,
        STP_F2  = 3'd6
    } step_e;

    typedef enum logic [1:0] {
        DST_PROD,
        DST_FOLD,
        DST_RES
    } dst_e;

    typedef struct packed {
        lane_t      x;
        lane_t      y;
        logic [1:0] lane_sh;
        dst_e       dst;
    } mul_op_t;

    function automatic wide_t place_lanes(lprod_t p, logic [1:0] sh);
        wide_t w;
        w = '0;
        w[LPROD_W-1:0] = p;
        return w << (int'(sh) * LANE_W);
    endfunction

    function automatic lane_t red_lane(logic [7:0] c);
        return {c, {(LANE_W-8){1'b0}}};
    endfunction

endpackage

// File: rtl/gfm_byte_rev.sv
module gfm_byte_rev #(
    parameter int NB = 16,
    parameter int BW = 8
) (
    input  logic [NB*BW-1:0] din,
    output logic [NB*BW-1:0] dout
);
    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign dout[g*BW +: BW] = din[(NB-1-g)*BW +: BW];
    end
endmodule

// File: rtl/gfm_clmul.sv
module gfm_clmul #(
    parameter int W = 64
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);
    logic [2*W-1:0] x_ext;
    logic [2*W-1:0] acc;

    assign x_ext = {{W{1'b0}}, x};

    always_comb begin
        acc = '0;
        for (int i = 0; i < W; i++) begin
            if (y[i]) begin
                acc = acc ^ (x_ext << i);
            end
        end
    end

    assign p = acc;
endmodule

// File: rtl/gfm_ctrl.sv
module gfm_ctrl
    import gfm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output logic  busy,
    output logic  accept,
    output logic  last,
    output step_e step
);
    state_e state_q;
    step_e  step_q;

    assign busy   = (state_q == ST_RUN);
    assign accept = (state_q == ST_IDLE) && start;
    assign last   = busy && (step_q == STP_F2);
    assign step   = step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= STP_LL;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        step_q  <= STP_LL;
                    end
                end
                default: begin
                    if (step_q == STP_F2) begin
                        state_q <= ST_IDLE;
                        step_q  <= STP_LL;
                    end else begin
                        step_q <= step_e'(step_q + 3'd1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/gcm_gfmul.sv
module gcm_gfmul
    import gfm_pkg::*;
#(
    parameter logic [7:0] RED_BYTE = 8'hE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BLK_W-1:0] opnd_x,
    input  logic [BLK_W-1:0] opnd_y,
    output logic             done,
    output logic [BLK_W-1:0] product
);
    localparam lane_t RED_HI = red_lane(RED_BYTE);

    logic  busy;
    logic  accept;
    logic  last;
    step_e step;

    blk_t  x_sw, y_sw;
    blk_t  a_q, b_q;
    prod_t prod_q;
    fold_t fr_q;
    blk_t  res_q;
    logic  done_q;

    wide_t   d_w;
    blk_t    t_hi;
    lane_t   t_mid;
    mul_op_t op;
    lprod_t  mp;
    blk_t    fin_sw;
    blk_t    fin_out;

    gfm_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .busy   (busy),
        .accept (accept),
        .last   (last),
        .step   (step)
    );

    gfm_byte_rev #(.NB(BLK_BYTES), .BW(BYTE_W)) u_rev_x (.din(opnd_x), .dout(x_sw));
    gfm_byte_rev #(.NB(BLK_BYTES), .BW(BYTE_W)) u_rev_y (.din(opnd_y), .dout(y_sw));

    // reflected product, corrected by one bit
    assign d_w   = {prod_q, 1'b0};
    // first fold after its one-bit correction: top half and the lane below it
    assign t_hi  = fr_q[FR_W-1:LANE_W-1];
    assign t_mid = {fr_q[LANE_W-2:0], 1'b0};

    always_comb begin
        op = '{x: '0, y: '0, lane_sh: 2'd0, dst: DST_PROD};
        case (step)
            STP_LL:  op = '{x: a_q[LANE_W-1:0], y: b_q[LANE_W-1:0], lane_sh: 2'd0, dst: DST_PROD};
            STP_LH:  op = '{x: a_q[LANE_W-1:0], y: b_q[BLK_W-1:LANE_W], lane_sh: 2'd1, dst: DST_PROD};
            STP_HL:  op = '{x: a_q[BLK_W-1:LANE_W], y: b_q[LANE_W-1:0], lane_sh: 2'd1, dst: DST_PROD};
            STP_HH:  op = '{x: a_q[BLK_W-1:LANE_W], y: b_q[BLK_W-1:LANE_W], lane_sh: 2'd2, dst: DST_PROD};
            STP_F1L: op = '{x: d_w[LANE_W-1:0], y: RED_HI, lane_sh: 2'd0, dst: DST_FOLD};
            STP_F1H: op = '{x: d_w[BLK_W-1:LANE_W], y: RED_HI, lane_sh: 2'd1, dst: DST_FOLD};
            STP_F2:  op = '{x: t_mid, y: RED_HI, lane_sh: 2'd0, dst: DST_RES};
            default: op = '{x: '0, y: '0, lane_sh: 2'd0, dst: DST_PROD};
        endcase
    end

    gfm_clmul #(.W(LANE_W)) u_mul (
        .x (op.x),
        .y (op.y),
        .p (mp)
    );

    // second fold lands only in the upper half; its one-bit correction
    // is the shift of the raw partial
    assign fin_sw = d_w[WIDE_W-1:BLK_W] ^ t_hi ^ {mp[LPROD_W-2:0], 1'b0};

    gfm_byte_rev #(.NB(BLK_BYTES), .BW(BYTE_W)) u_rev_out (.din(fin_sw), .dout(fin_out));

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            prod_q <= '0;
            fr_q   <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (accept) begin
                a_q    <= x_sw;
                b_q    <= y_sw;
                prod_q <= '0;
                fr_q   <= '0;
            end else if (busy) begin
                case (op.dst)
                    DST_PROD: prod_q <= prod_q ^ prod_t'(place_lanes(mp, op.lane_sh));
                    DST_FOLD: fr_q   <= fr_q ^ (fold_t'(mp) << (int'(op.lane_sh) * LANE_W));
                    default:  res_q  <= fin_out;
                endcase
            end
        end
    end

    assign done    = done_q;
    assign product = res_q;
endmodule

// File: rtl/gfm_mul_chk.sv
module gfm_mul_chk
    import gfm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [BLK_W-1:0] product
);
    localparam int LAT = 8;

    logic [3:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start && !busy) begin
            cnt <= 4'd1;
        end else if (cnt != 4'd0 && cnt != 4'(LAT)) begin
            cnt <= cnt + 4'd1;
        end else begin
            cnt <= '0;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done == (cnt == 4'(LAT))); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(product)); // R8

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy)); // R9
endmodule

bind gcm_gfmul gfm_mul_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/tb_gcm_gfmul.sv
module tb_gcm_gfmul;
    localparam int CLK_PERIOD = 10;
    localparam int EXP_LAT    = 8;
    localparam int N_RAND     = 40;
    localparam int WD_CYCLES  = 150000;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [127:0] opnd_x, opnd_y;
    logic         done;
    logic [127:0] product;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gcm_gfmul dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .opnd_x  (opnd_x),
        .opnd_y  (opnd_y),
        .done    (done),
        .product (product)
    );

    function automatic logic [127:0] swap16(logic [127:0] v);
        logic [127:0] r;
        for (int k = 0; k < 16; k++) r[k*8 +: 8] = v[(15-k)*8 +: 8];
        return r;
    endfunction

    function automatic logic [127:0] ref_mul(logic [127:0] xa, logic [127:0] ya);
        logic [127:0] xv, v, z;
        xv = swap16(xa);
        v  = swap16(ya);
        z  = '0;
        for (int i = 0; i < 128; i++) begin
            if (xv[127-i]) z = z ^ v;
            if (v[0]) v = (v >> 1) ^ {8'hE1, 120'd0};
            else      v = v >> 1;
        end
        return swap16(z);
    endfunction

    function automatic logic [127:0] rand128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic chk_val(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_int(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // drive at a negedge; return after the negedge at which done is seen
    task automatic launch(input logic [127:0] xa, input logic [127:0] ya);
        start  = 1'b1;
        opnd_x = xa;
        opnd_y = ya;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin
                lat = k;
                break;
            end
        end
    endtask

    task automatic run_one(input string req, input logic [127:0] xa, input logic [127:0] ya);
        int lat;
        @(negedge clk);
        launch(xa, ya);
        wait_done(lat);
        chk_int({req, " latency R6"}, lat, EXP_LAT);
        chk_val(req, product, ref_mul(xa, ya));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] ones, one, p, q, r1;
        int lat, extra;
        void'($urandom(32'h5EED_0F12));
        ones = '1;
        one  = 128'h80;
        rst = 1'b1; start = 1'b0; opnd_x = '0; opnd_y = '0;
        repeat (3) @(negedge clk);
        chk_int("R10 done after reset", int'(done), 0);
        chk_val("R10 product after reset", product, '0);
        rst = 1'b0;
        @(negedge clk);
        chk_int("R10 done idle", int'(done), 0);

        // R1: x * x^127 = x^128 mod P -> 0xE1 in byte 0
        run_one("R1 layout", 128'h40, 128'h01 << 120);
        chk_val("R1 remainder", product, 128'hE1);

        p = rand128();
        run_one("R4 unit left", one, p);
        chk_val("R4 unit left value", product, p);
        run_one("R4 unit right", p, one);
        chk_val("R4 unit right value", product, p);

        run_one("R3 zero left", '0, rand128());
        chk_val("R3 zero left value", product, '0);
        run_one("R3 zero right", ones, '0);
        chk_val("R3 zero right value", product, '0);

        run_one("R5 all ones", ones, ones);
        run_one("R5 ones by random", ones, rand128());
        run_one("R5 high bytes", 128'hFF << 120, 128'hFF << 120);

        for (int n = 0; n < N_RAND; n++) begin
            run_one("R2 random", rand128(), rand128());
        end

        // R7: start in the middle of a run is ignored
        p = rand128(); q = rand128(); r1 = ref_mul(p, q);
        @(negedge clk);
        launch(p, q);
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        @(negedge clk); launch(rand128(), rand128());
        lat = 3;
        for (int k = 4; k <= 20; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin lat = k; break; end
        end
        chk_int("R7 latency kept", lat, EXP_LAT);
        chk_val("R7 first result kept", product, r1);
        extra = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk_int("R7 no extra done", extra, 0);
        chk_val("R8 product held", product, r1);

        // R9: start in the cycle done is high
        p = rand128(); q = rand128();
        @(negedge clk);
        launch(p, q);
        wait_done(lat);
        chk_int("R9 first latency", lat, EXP_LAT);
        chk_val("R9 first result", product, ref_mul(p, q));
        p = rand128(); q = rand128();
        launch(p, q);
        wait_done(lat);
        chk_int("R9 second latency", lat, EXP_LAT);
        chk_val("R9 second result", product, ref_mul(p, q));
        @(negedge clk);
        chk_int("R6 done single cycle", int'(done), 0);

        finish_run();
    end
endmodule